// File: doc/BRIEF.md
# Hierarchical Route Selector

This block chooses the output port for a packet header in a two-level direct network. Octants are grouped into supernodes. Octants in the same supernode are joined by local links, and supernodes are joined by distance links. Each header carries a destination supernode and a destination octant. When the supernode matches the router's own supernode, the octant indexes a small local route table. Otherwise the supernode indexes a larger distance route table. Software fills both tables through a write port.

Each table entry lists up to four candidate output ports and marks the entry as direct or indirect. Candidates whose link is down, that are not marked valid, or whose port number is out of range are passed over. Among the remaining candidates, the block picks by round-robin, or by a pseudo-random start point when the header asks for it and the entry is indirect. Listing several candidates gives striping over equivalent paths and failover when a link drops. One decision is accepted every cycle, and its result appears one cycle later.

Top module: `route_selector`

## Requirements
- R1: After reset, `out_valid`, `out_err` and `out_port` are 0, and every table entry is empty, so any lookup reports an error.
- R2: If `hdr_sn` equals `self_sn`, the lookup uses the local table indexed by `hdr_oct`. Otherwise it uses the distance table indexed by `hdr_sn`.
- R3: A table entry is written as 29 bits on `cfg_wdata`: candidate k port number in bits [6k+5:6k] (k = 0..3), candidate valid flags in bits [27:24] (bit 24+k for candidate k), and the indirect flag in bit 28. `cfg_sel` = 0 writes the local table at `cfg_idx[4:0]`. `cfg_sel` = 1 writes the distance table at `cfg_idx`.
- R4: A header presented with `hdr_valid` high at a clock edge produces `out_valid` high for exactly the following cycle. Without a header, `out_valid` is low and `out_port` and `out_err` are 0.
- R5: A candidate is usable only if its valid flag is set, its port number is below 51, and `link_down` at that port is 0 in the cycle of the header. Unusable candidates are never chosen.
- R6: If no candidate is usable, the result has `out_err` = 1 and `out_port` = 0.
- R7: Round-robin keeps one 2-bit pointer per table level, both 0 after reset. The search starts at the pointer and walks upward through candidate slots, wrapping after slot 3. It takes the first usable slot, and the pointer becomes that slot plus one, modulo 4. The pointer does not change on an error or on a random decision.
- R8: Random selection applies only when `hdr_rand` = 1 and the entry's indirect flag is set. A direct entry with `hdr_rand` = 1 uses round-robin. A random search starts at slot `lfsr[1:0]` and otherwise walks like R7. The 16-bit LFSR resets to 16'h0001 and steps as `{lfsr[14:0], lfsr[15]^lfsr[13]^lfsr[12]^lfsr[10]}` once after every random decision, including a decision that ends in error.
- R9: A table write in the same cycle as a header lookup does not affect that lookup. The lookup sees the old entry, and the next header sees the new one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| self_sn | input | 9 | Supernode number of this router |
| hdr_valid | input | 1 | Header present this cycle |
| hdr_sn | input | 9 | Destination supernode |
| hdr_oct | input | 5 | Destination octant |
| hdr_rand | input | 1 | Header requests random choice among indirect routes |
| link_down | input | 51 | Per-output-port failed-link flags |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 1 | 0 selects the local table, 1 selects the distance table |
| cfg_idx | input | 9 | Table entry index |
| cfg_wdata | input | 29 | Entry contents |
| out_valid | output | 1 | Decision valid |
| out_port | output | 6 | Chosen output port |
| out_err | output | 1 | No usable candidate |

## Verification
The bench targets the following corner cases:

- **Same-cycle write and lookup.** A write and a lookup land on the same entry in one cycle. A design that forwards the write would return the new port one decision early.
- **Round-robin wrap and failover.** The bench checks that the pointer wraps after slot 3 and skips down or invalid slots. It also checks that the pointer holds on errors. A design that advanced the pointer blindly would repeat or skip candidates.
- **Random versus round-robin by entry class.** Headers that request random choice are sent to direct entries and to indirect entries. A design that ignored the entry class would jump where it should rotate. A design that stepped the LFSR on the wrong events would drift off the expected sequence.
- **Out-of-range ports and index truncation.** The bench uses candidate port numbers of 51 and above, and local writes with high index bits set. These catch a design that forwards an unusable port or misplaces a local entry.

// File: rtl/rsel_pkg.sv
package rsel_pkg;
    localparam int SN_W      = 9;
    localparam int OCT_W     = 5;
    localparam int PORT_W    = 6;
    localparam int NUM_PORTS = 51;
    localparam int NCAND     = 4;
    localparam int SLOT_W    = $clog2(NCAND);
    localparam int LFSR_W    = 16;

    typedef struct packed {
        logic                              indirect;
        logic [NCAND-1:0]                  vld;
        logic [NCAND-1:0][PORT_W-1:0]      port;
    } entry_t;

    localparam int ENTRY_W = $bits(entry_t);
endpackage

// File: rtl/rsel_table.sv
module rsel_table
    import rsel_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  entry_t           wdata,
    input  logic [IDX_W-1:0] ridx,
    output entry_t           rdata
);
    entry_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[widx] <= wdata;
        end
    end

    assign rdata = mem_q[ridx];
endmodule

// File: rtl/rsel_pick.sv
module rsel_pick
    import rsel_pkg::*;
(
    input  entry_t              ent,
    input  logic [NUM_PORTS-1:0] link_down,
    input  logic [SLOT_W-1:0]   start,
    output logic                hit,
    output logic [SLOT_W-1:0]   slot,
    output logic [PORT_W-1:0]   port
);
    logic [NCAND-1:0] usable;

    for (genvar k = 0; k < NCAND; k++) begin : g_use
        logic in_range;
        assign in_range = ent.port[k] < PORT_W'(NUM_PORTS);
        assign usable[k] = ent.vld[k] && in_range &&
                           !link_down[in_range ? ent.port[k] : '0];
    end

    always_comb begin
        hit  = 1'b0;
        slot = '0;
        for (int k = 0; k < NCAND; k++) begin
            logic [SLOT_W-1:0] j;
            j = start + SLOT_W'(k);
            if (!hit && usable[j]) begin
                hit  = 1'b1;
                slot = j;
            end
        end
        port = hit ? ent.port[slot] : '0;
    end
endmodule

// File: rtl/route_selector.sv
module route_selector
    import rsel_pkg::*;
#(
    parameter int NUM_SN  = 512,
    parameter int NUM_OCT = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SN_W-1:0]       self_sn,
    input  logic                  hdr_valid,
    input  logic [SN_W-1:0]       hdr_sn,
    input  logic [OCT_W-1:0]      hdr_oct,
    input  logic                  hdr_rand,
    input  logic [NUM_PORTS-1:0]  link_down,
    input  logic                  cfg_we,
    input  logic                  cfg_sel,
    input  logic [SN_W-1:0]       cfg_idx,
    input  logic [ENTRY_W-1:0]    cfg_wdata,
    output logic                  out_valid,
    output logic [PORT_W-1:0]     out_port,
    output logic                  out_err
);
    localparam int LOC_IW = $clog2(NUM_OCT);
    localparam int DST_IW = $clog2(NUM_SN);

    typedef struct packed {
        logic              out_valid;
        logic [PORT_W-1:0] out_port;
        logic              out_err;
        logic [SLOT_W-1:0] rr_loc;
        logic [SLOT_W-1:0] rr_dst;
        logic [LFSR_W-1:0] lfsr;
    } state_t;

    state_t st_d, st_q;

    entry_t loc_rd, dst_rd, ent;
    logic   is_local, use_rand, hit;
    logic [SLOT_W-1:0] start, slot;
    logic [PORT_W-1:0] pick_port;

    rsel_table #(.DEPTH(NUM_OCT)) u_loc_tbl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we && !cfg_sel),
        .widx  (cfg_idx[LOC_IW-1:0]),
        .wdata (entry_t'(cfg_wdata)),
        .ridx  (hdr_oct[LOC_IW-1:0]),
        .rdata (loc_rd)
    );

    rsel_table #(.DEPTH(NUM_SN)) u_dst_tbl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we && cfg_sel),
        .widx  (cfg_idx[DST_IW-1:0]),
        .wdata (entry_t'(cfg_wdata)),
        .ridx  (hdr_sn[DST_IW-1:0]),
        .rdata (dst_rd)
    );

    assign is_local = (hdr_sn == self_sn);
    assign ent      = is_local ? loc_rd : dst_rd;
    assign use_rand = hdr_rand && ent.indirect;
    assign start    = use_rand ? st_q.lfsr[SLOT_W-1:0]
                    : (is_local ? st_q.rr_loc : st_q.rr_dst);

    rsel_pick u_pick (
        .ent       (ent),
        .link_down (link_down),
        .start     (start),
        .hit       (hit),
        .slot      (slot),
        .port      (pick_port)
    );

    always_comb begin
        st_d           = st_q;
        st_d.out_valid = hdr_valid;
        st_d.out_port  = '0;
        st_d.out_err   = 1'b0;
        if (hdr_valid) begin
            st_d.out_err  = !hit;
            st_d.out_port = pick_port;
            if (use_rand) begin
                st_d.lfsr = {st_q.lfsr[LFSR_W-2:0],
                             st_q.lfsr[15] ^ st_q.lfsr[13] ^
                             st_q.lfsr[12] ^ st_q.lfsr[10]};
            end else if (hit) begin
                if (is_local) st_d.rr_loc = slot + 1'b1;
                else          st_d.rr_dst = slot + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.lfsr <= LFSR_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.out_valid;
    assign out_port  = st_q.out_port;
    assign out_err   = st_q.out_err;
endmodule

// File: rtl/route_selector_chk.sv
module route_selector_chk
    import rsel_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 hdr_valid,
    input logic [NUM_PORTS-1:0] link_down,
    input logic                 out_valid,
    input logic [PORT_W-1:0]    out_port,
    input logic                 out_err,
    input logic [SLOT_W-1:0]    rr_loc,
    input logic [SLOT_W-1:0]    rr_dst
);
    logic [NUM_PORTS-1:0] ld_p;
    always_ff @(posedge clk) ld_p <= link_down;

    a_r4_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> out_valid);
    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid |=> (!out_valid && out_port == '0 && !out_err));
    a_r6_err_port_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err) |-> out_port == '0);
    a_r5_port_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_err) |-> out_port < PORT_W'(NUM_PORTS));
    a_r5_port_link_up: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> (out_err || !ld_p[out_port < PORT_W'(NUM_PORTS) ? out_port : '0]));
    a_r7_ptr_hold_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err) |-> ($stable(rr_loc) && $stable(rr_dst)));
endmodule

bind route_selector route_selector_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hdr_valid (hdr_valid),
    .link_down (link_down),
    .out_valid (out_valid),
    .out_port  (out_port),
    .out_err   (out_err),
    .rr_loc    (st_q.rr_loc),
    .rr_dst    (st_q.rr_dst)
);

// File: tb/route_selector_tb.sv
`timescale 1ns/1ps
module route_selector_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [8:0]  self_sn = 9'd5;
    logic        hdr_valid = 0;
    logic [8:0]  hdr_sn = 0;
    logic [4:0]  hdr_oct = 0;
    logic        hdr_rand = 0;
    logic [50:0] link_down = 0;
    logic        cfg_we = 0, cfg_sel = 0;
    logic [8:0]  cfg_idx = 0;
    logic [28:0] cfg_wdata = 0;
    logic        out_valid, out_err;
    logic [5:0]  out_port;

    int errors = 0, checks = 0;

    logic [28:0] m_loc [32];
    logic [28:0] m_dst [512];
    logic [1:0]  m_rr_loc, m_rr_dst;
    logic [15:0] m_lfsr;

    always #4 clk = ~clk;

    route_selector u_dut (
        .clk(clk), .rst_n(rst_n), .self_sn(self_sn), .hdr_valid(hdr_valid),
        .hdr_sn(hdr_sn), .hdr_oct(hdr_oct), .hdr_rand(hdr_rand),
        .link_down(link_down), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .out_valid(out_valid),
        .out_port(out_port), .out_err(out_err)
    );

    function automatic logic [28:0] mk(input logic ind, input logic [3:0] v,
        input logic [5:0] p0, p1, p2, p3);
        return {ind, v, p3, p2, p1, p0};
    endfunction

    task automatic check(input logic ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input logic hv, input logic [8:0] sn, input logic [4:0] oct,
                       input logic rnd, input logic [50:0] ld,
                       input logic we, input logic sel, input logic [8:0] idx,
                       input logic [28:0] wd, input string tag);
        logic        loc, ur, hit;
        logic [28:0] e;
        logic [1:0]  st, sl;
        logic [5:0]  ep;
        hdr_valid = hv; hdr_sn = sn; hdr_oct = oct; hdr_rand = rnd;
        link_down = ld; cfg_we = we; cfg_sel = sel; cfg_idx = idx; cfg_wdata = wd;
        loc = (sn == self_sn);
        e   = loc ? m_loc[oct] : m_dst[sn];
        ur  = rnd && e[28];
        st  = ur ? m_lfsr[1:0] : (loc ? m_rr_loc : m_rr_dst);
        hit = 0; sl = 0; ep = 0;
        for (int k = 0; k < 4; k++) begin
            logic [1:0] j;
            logic [5:0] p;
            j = st + 2'(k);
            p = e[6*j +: 6];
            if (!hit && e[24+j] && p < 6'd51 && !ld[p]) begin
                hit = 1; sl = j; ep = p;
            end
        end
        if (hv) begin
            if (ur) m_lfsr = {m_lfsr[14:0], m_lfsr[15]^m_lfsr[13]^m_lfsr[12]^m_lfsr[10]};
            else if (hit) begin
                if (loc) m_rr_loc = sl + 2'd1; else m_rr_dst = sl + 2'd1;
            end
        end
        if (we) begin
            if (sel) m_dst[idx] = wd; else m_loc[idx[4:0]] = wd;
        end
        @(negedge clk);
        if (hv) begin
            check(out_valid === 1'b1, tag, "out_valid", out_valid, 1);
            check(out_err === !hit, tag, "out_err", out_err, !hit);
            check(out_port === ep, tag, "out_port", out_port, ep);
        end else begin
            check(out_valid === 1'b0 && out_port === 0 && out_err === 0, tag,
                  "idle outputs", {out_valid, out_err, out_port}, 0);
        end
    endtask

    task automatic wr(input logic sel, input logic [8:0] idx, input logic [28:0] wd);
        cyc(0, 0, 0, 0, '0, 1, sel, idx, wd, "R3");
    endtask

    task automatic look(input logic [8:0] sn, input logic [4:0] oct, input logic rnd,
                        input logic [50:0] ld, input string tag);
        cyc(1, sn, oct, rnd, ld, 0, 0, 0, '0, tag);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 32; i++) m_loc[i] = '0;
        for (int i = 0; i < 512; i++) m_dst[i] = '0;
        m_rr_loc = 0; m_rr_dst = 0; m_lfsr = 16'h0001;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset outputs
        check(out_valid === 0 && out_err === 0 && out_port === 0, "R1",
              "reset outputs", {out_valid, out_err, out_port}, 0);
        // R1, R6: empty tables give errors
        look(9'd5, 5'd3, 0, '0, "R1");
        look(9'd100, 5'd0, 1, '0, "R6");
        // R2, R7: local round-robin with wrap
        wr(0, 9'd3, mk(0, 4'hF, 6'd10, 6'd11, 6'd12, 6'd13));
        for (int i = 0; i < 5; i++) look(9'd5, 5'd3, 0, '0, "R7");
        // R2: distance table used when supernodes differ
        wr(1, 9'd100, mk(1, 4'b1011, 6'd40, 6'd41, 6'd42, 6'd43));
        wr(1, 9'd5, mk(0, 4'h1, 6'd1, 6'd0, 6'd0, 6'd0));
        look(9'd100, 5'd3, 0, '0, "R2");
        look(9'd100, 5'd3, 0, '0, "R7");
        look(9'd100, 5'd3, 0, '0, "R7");
        // R5: link down and out-of-range ports skipped
        look(9'd5, 5'd3, 0, 51'(1) << 11, "R5");
        look(9'd5, 5'd3, 0, (51'(1) << 12) | (51'(1) << 13), "R5");
        wr(0, 9'd7, mk(0, 4'hF, 6'd60, 6'd51, 6'd63, 6'd20));
        look(9'd5, 5'd7, 0, '0, "R5");
        // R6: all candidates down, pointer held
        look(9'd5, 5'd3, 0, 51'hF << 10, "R6");
        look(9'd5, 5'd3, 0, '0, "R7");
        // R8: random on indirect entry, round-robin on direct entry
        for (int i = 0; i < 6; i++) look(9'd100, 5'd0, 1, '0, "R8");
        look(9'd5, 5'd3, 1, '0, "R8");
        look(9'd100, 5'd0, 1, 51'h7 << 40, "R8");
        // R9: same-cycle write sees old entry
        cyc(1, 9'd5, 5'd3, 0, '0, 1, 0, 9'd3, mk(0, 4'h1, 6'd30, 6'd0, 6'd0, 6'd0), "R9");
        look(9'd5, 5'd3, 0, '0, "R9");
        // R3: local index truncated to low bits
        wr(0, 9'h1E4, mk(0, 4'h2, 6'd0, 6'd33, 6'd0, 6'd0));
        look(9'd5, 5'd4, 0, '0, "R3");
        // R4: idle cycle
        cyc(0, 9'd5, 5'd3, 0, '0, 0, 0, 0, '0, "R4");
        // random mix
        for (int n = 0; n < 600; n++) begin
            logic [50:0] ld;
            logic [8:0]  sn;
            ld = '0;
            for (int b = 0; b < 51; b++) ld[b] = ($urandom % 8) == 0;
            sn = 9'($urandom % 8);
            if (($urandom % 6) == 0)
                cyc($urandom % 2, sn, 5'($urandom % 8), $urandom % 2, ld, 1,
                    $urandom % 2, 9'($urandom % 8),
                    mk($urandom % 2, 4'($urandom), 6'($urandom % 56), 6'($urandom % 56),
                       6'($urandom % 56), 6'($urandom % 56)), "R2");
            else
                cyc(($urandom % 4) != 0, sn, 5'($urandom % 8), $urandom % 2, ld,
                    0, 0, 0, '0, "R7");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule